// File: doc/BRIEF.md
# Sliding Reference Window Buffer for Integer Motion Search

This block holds the reference pixels that an integer motion search engine needs while it processes one row of 16x16 macroblocks. It keeps the reference area as vertical strips, each 16 columns wide and 47 rows tall, in four separate single-port banks. Three banks together form the 48-column window the matching engine reads. The fourth bank is filled with the next strip from external memory while those reads go on. When the search for a macroblock finishes, the window slides right by one strip. The strip that has dropped off the left edge becomes the next load target. Each step therefore fetches only 16 new columns instead of a full window.

At the start of every macroblock row the buffer is cleared. It then asks for three strips before it declares the window usable. Strips arrive as a stream of row beats, one 16-pixel row per beat, top row first. The search engine asks for a row index and a starting column inside the window. Two cycles later it receives 16 consecutive reference pixels, assembled from one or two banks.

Top module: `swin_refbuf`

## Requirements
- R1: After reset, `win_ready` and `rd_valid` are low, and they stay low until strips are loaded.
- R2: A strip is 47 load beats with `ld_valid` high, one per row from row 0 upward. Byte j of `ld_data` (bits 8j+7:8j) is strip column j. `win_ready` rises only when the third strip after a row start has completed.
- R3: A read of row r and column c, with 0 <= c <= 32, gives `rd_valid` high exactly two cycles later. Byte i of `rd_data` then holds window column c+i of row r.
- R4: Window column c comes from window strip c/16, column c mod 16. Strip 0 is the oldest strip still in the window. A `mb_done` pulse while ready moves every strip one place left, so the old strip 1 becomes strip 0.
- R5: While ready, the buffer accepts the next strip into the spare bank at the same time as reads, and the read data are unaffected.
- R6: If `mb_done` arrives while ready and no fourth strip has finished loading, `win_ready` drops until the missing strip completes. A `mb_done` while not ready has no effect on the window.
- R7: When four complete strips are held, extra load beats are ignored and change no stored pixel.
- R8: Read requests are ignored and produce no `rd_valid` while the window is not ready, or when the column is above 32 or the row is above 46.
- R9: `row_start` discards the whole window. `win_ready` falls, and three new strips are needed, the first of which becomes window strip 0.
- R10: No bank is read and written in the same cycle, and the load target is never one of the three banks being read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| row_start | input | 1 | Pulse: begin a new macroblock row, clear the window |
| mb_done | input | 1 | Pulse: macroblock search finished, slide window by one strip |
| ld_valid | input | 1 | Load beat valid |
| ld_data | input | 128 | One strip row, 16 pixels, byte j = column j |
| rd_en | input | 1 | Read request |
| rd_row | input | 6 | Window row of the read, 0 to 46 |
| rd_col | input | 6 | First window column of the read, 0 to 32 |
| rd_valid | output | 1 | Read data valid, two cycles after an accepted request |
| rd_data | output | 128 | 16 reference pixels, byte i = column rd_col+i |
| win_ready | output | 1 | Three strips loaded; reads are accepted |

## Verification
If the rotating base pointer or the fill count goes wrong, the pixels seen at `rd_data` come from the wrong strip. This shows at once on the first read after the faulty `mb_done` or load, because every strip carries a distinct, computable pattern. If the load target hits a live bank, or extra beats are not dropped, the next full sweep of the 47x33 read positions shows corrupted bytes. A `win_ready` that rises or falls at the wrong time shows within one cycle of the strip boundary or slide that caused it.

// File: rtl/swin_pkg.sv
package swin_pkg;
  localparam int PIX_W_D   = 8;
  localparam int STRIP_W_D = 16;
  localparam int ROWS_D    = 47;
  localparam int NBANK_D   = 4;
  localparam int LIVE_D    = 3;
endpackage

// File: rtl/swin_bank.sv
module swin_bank #(
  parameter int ROWS   = 47,
  parameter int WORD_W = 128
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    we,
  input  logic                    re,
  input  logic [$clog2(ROWS)-1:0] addr_w,
  input  logic [$clog2(ROWS)-1:0] addr_r,
  input  logic [WORD_W-1:0]       wdata,
  output logic [WORD_W-1:0]       rdata
);
  localparam int AW = $clog2(ROWS);

  logic [WORD_W-1:0] mem [ROWS];
  logic [AW-1:0]     addr;

  assign addr = we ? addr_w : addr_r;

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
    else if (re) rdata <= mem[addr];
  end

  assert_single_port_R10: assert property (@(posedge clk) disable iff (rst) !(we && re))
    else $error("bank read and write in one cycle");
endmodule

// File: rtl/swin_ctrl.sv
module swin_ctrl #(
  parameter int ROWS  = 47,
  parameter int NBANK = 4,
  parameter int LIVE  = 3
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     row_start,
  input  logic                     mb_done,
  input  logic                     ld_valid,
  output logic                     ld_fire,
  output logic [$clog2(NBANK)-1:0] ld_bank,
  output logic [$clog2(ROWS)-1:0]  ld_row,
  output logic [$clog2(NBANK)-1:0] base,
  output logic                     ready
);
  localparam int BW = $clog2(NBANK);
  localparam int RW = $clog2(ROWS);
  localparam int FW = $clog2(NBANK + 1);

  logic [FW-1:0] fill_q, fill_n;
  logic [RW-1:0] row_q;
  logic [BW-1:0] base_q;
  logic          rdy_q;
  logic          strip_end, advance;
  logic [FW-1:0] slot;

  assign ld_fire   = ld_valid && !row_start && (fill_q < FW'(NBANK));
  assign strip_end = ld_fire && (row_q == RW'(ROWS - 1));
  assign advance   = mb_done && !row_start && (fill_q >= FW'(LIVE));
  assign fill_n    = fill_q + FW'(strip_end) - FW'(advance);
  assign slot      = (fill_q > FW'(LIVE)) ? FW'(LIVE) : fill_q;
  assign ld_bank   = base_q + BW'(slot);
  assign ld_row    = row_q;
  assign base      = base_q;
  assign ready     = rdy_q;

  always_ff @(posedge clk) begin
    if (rst || row_start) begin
      fill_q <= '0;
      row_q  <= '0;
      base_q <= '0;
      rdy_q  <= 1'b0;
    end else begin
      fill_q <= fill_n;
      base_q <= base_q + BW'(advance);
      rdy_q  <= (fill_n >= FW'(LIVE));
      if (strip_end)    row_q <= '0;
      else if (ld_fire) row_q <= row_q + 1'b1;
    end
  end

  assert_fill_bound_R7: assert property (@(posedge clk) disable iff (rst) fill_q <= FW'(NBANK))
    else $error("fill count above bank count");
  assert_ready_rise_R2: assert property (@(posedge clk) disable iff (rst)
    $rose(rdy_q) |-> $past(ld_fire))
    else $error("ready rose without a load beat");
  assert_slide_R4: assert property (@(posedge clk) disable iff (rst || row_start)
    advance |=> base_q == BW'($past(base_q) + 1'b1))
    else $error("base did not advance");
endmodule

// File: rtl/swin_align.sv
module swin_align #(
  parameter int PIX_W   = 8,
  parameter int STRIP_W = 16
) (
  input  logic                       clk,
  input  logic                       rst,
  input  logic                       in_valid,
  input  logic [$clog2(STRIP_W)-1:0] off,
  input  logic [PIX_W*STRIP_W-1:0]   lo_w,
  input  logic [PIX_W*STRIP_W-1:0]   hi_w,
  output logic                       out_valid,
  output logic [PIX_W*STRIP_W-1:0]   out_data
);
  localparam int WW = PIX_W * STRIP_W;
  localparam int SH = $clog2(WW) + 1;

  logic [SH-1:0]   sh;
  logic [2*WW-1:0] cat;

  assign sh  = SH'(off) * SH'(PIX_W);
  assign cat = {hi_w, lo_w} >> sh;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid <= 1'b0;
      out_data  <= '0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) out_data <= cat[WW-1:0];
    end
  end
endmodule

// File: rtl/swin_refbuf.sv
module swin_refbuf
  import swin_pkg::*;
#(
  parameter int PIX_W   = PIX_W_D,
  parameter int STRIP_W = STRIP_W_D,
  parameter int ROWS    = ROWS_D,
  parameter int NBANK   = NBANK_D,
  parameter int LIVE    = LIVE_D
) (
  input  logic                                clk,
  input  logic                                rst,
  input  logic                                row_start,
  input  logic                                mb_done,
  input  logic                                ld_valid,
  input  logic [PIX_W*STRIP_W-1:0]            ld_data,
  input  logic                                rd_en,
  input  logic [$clog2(ROWS)-1:0]             rd_row,
  input  logic [$clog2(LIVE*STRIP_W)-1:0]     rd_col,
  output logic                                rd_valid,
  output logic [PIX_W*STRIP_W-1:0]            rd_data,
  output logic                                win_ready
);
  localparam int WW = PIX_W * STRIP_W;
  localparam int RW = $clog2(ROWS);
  localparam int CW = $clog2(LIVE * STRIP_W);
  localparam int BW = $clog2(NBANK);
  localparam int OW = $clog2(STRIP_W);
  localparam int MAX_COL = (LIVE - 1) * STRIP_W;

  logic          ld_fire;
  logic [BW-1:0] ld_bank, base;
  logic [RW-1:0] ld_row;
  logic          rd_fire, need_hi;
  logic [BW-1:0] lo_bank, hi_bank;
  logic [OW-1:0] off;
  logic [NBANK-1:0] bank_re, bank_we;
  logic [WW-1:0] bank_q [NBANK];

  logic          s1_valid;
  logic [BW-1:0] s1_lo, s1_hi;
  logic [OW-1:0] s1_off;

  swin_ctrl #(.ROWS(ROWS), .NBANK(NBANK), .LIVE(LIVE)) u_ctrl (
    .clk(clk), .rst(rst), .row_start(row_start), .mb_done(mb_done),
    .ld_valid(ld_valid), .ld_fire(ld_fire), .ld_bank(ld_bank),
    .ld_row(ld_row), .base(base), .ready(win_ready)
  );

  assign rd_fire = rd_en && win_ready && !row_start &&
                   (rd_col <= CW'(MAX_COL)) && (rd_row < RW'(ROWS));
  assign off     = rd_col[OW-1:0];
  assign need_hi = (off != '0);
  assign lo_bank = base + BW'(rd_col >> OW);
  assign hi_bank = lo_bank + 1'b1;

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    assign bank_we[b] = ld_fire && (ld_bank == BW'(b));
    assign bank_re[b] = rd_fire && ((lo_bank == BW'(b)) || (need_hi && (hi_bank == BW'(b))));
    swin_bank #(.ROWS(ROWS), .WORD_W(WW)) u_bank (
      .clk(clk), .rst(rst), .we(bank_we[b]), .re(bank_re[b]),
      .addr_w(ld_row), .addr_r(rd_row), .wdata(ld_data), .rdata(bank_q[b])
    );
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      s1_valid <= 1'b0;
      s1_lo    <= '0;
      s1_hi    <= '0;
      s1_off   <= '0;
    end else begin
      s1_valid <= rd_fire;
      s1_lo    <= lo_bank;
      s1_hi    <= hi_bank;
      s1_off   <= off;
    end
  end

  swin_align #(.PIX_W(PIX_W), .STRIP_W(STRIP_W)) u_align (
    .clk(clk), .rst(rst), .in_valid(s1_valid), .off(s1_off),
    .lo_w(bank_q[s1_lo]), .hi_w(bank_q[s1_hi]),
    .out_valid(rd_valid), .out_data(rd_data)
  );

  assert_target_idle_R10: assert property (@(posedge clk) disable iff (rst)
    ld_fire |-> !bank_re[ld_bank])
    else $error("load target is being read");
  assert_latency_R3: assert property (@(posedge clk) disable iff (rst)
    rd_fire |-> ##2 rd_valid)
    else $error("read data missing two cycles after request");
  assert_no_spurious_R8: assert property (@(posedge clk) disable iff (rst)
    rd_valid |-> $past(rd_fire, 2))
    else $error("read data without accepted request");
  assert_reset_quiet_R1: assert property (@(posedge clk)
    $past(rst) |-> !rd_valid && !win_ready)
    else $error("outputs active right after reset");
endmodule

// File: tb/sim_swin_refbuf.sv
module sim_swin_refbuf;
  localparam int ROWS = 47;
  localparam int SW   = 16;
  localparam int WW   = 128;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic row_start = 1'b0, mb_done = 1'b0, ld_valid = 1'b0, rd_en = 1'b0;
  logic [WW-1:0] ld_data = '0;
  logic [5:0] rd_row = '0, rd_col = '0;
  logic rd_valid, win_ready;
  logic [WW-1:0] rd_data;

  int n_run = 0, n_fail = 0;
  bit finished = 0;

  always #2 clk = ~clk;

  swin_refbuf u0 (
    .clk(clk), .rst(rst), .row_start(row_start), .mb_done(mb_done),
    .ld_valid(ld_valid), .ld_data(ld_data), .rd_en(rd_en), .rd_row(rd_row),
    .rd_col(rd_col), .rd_valid(rd_valid), .rd_data(rd_data), .win_ready(win_ready)
  );

  function automatic logic [7:0] pix(int g, int r, int j);
    return 8'((g * 53 + r * 7 + j * 13 + r * j) & 255);
  endfunction

  function automatic logic [WW-1:0] strip_row(int g, int r);
    logic [WW-1:0] w;
    for (int j = 0; j < SW; j++) w[j*8 +: 8] = pix(g, r, j);
    return w;
  endfunction

  function automatic logic [WW-1:0] expect_w(int first, int r, int c);
    logic [WW-1:0] w;
    for (int i = 0; i < SW; i++) w[i*8 +: 8] = pix(first + (c + i) / SW, r, (c + i) % SW);
    return w;
  endfunction

  task automatic chk(bit ok, string req, logic [WW-1:0] act, logic [WW-1:0] exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic load_strip(int g);
    for (int r = 0; r < ROWS; r++) begin
      @(negedge clk);
      ld_valid = 1'b1;
      ld_data  = strip_row(g, r);
    end
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  task automatic pulse_mb();
    @(negedge clk); mb_done = 1'b1;
    @(negedge clk); mb_done = 1'b0;
  endtask

  task automatic read_chk(int first, int r, int c, string req);
    @(negedge clk);
    rd_en = 1'b1; rd_row = 6'(r); rd_col = 6'(c);
    @(negedge clk);
    rd_en = 1'b0;
    @(negedge clk);
    chk(rd_valid === 1'b1 && rd_data === expect_w(first, r, c), req,
        {rd_data[WW-2:0], rd_valid}, {expect_w(first, r, c)[WW-2:0], 1'b1});
  endtask

  task automatic read_none(int r, int c, string req);
    bit seen = 0;
    @(negedge clk);
    rd_en = 1'b1; rd_row = 6'(r); rd_col = 6'(c);
    @(negedge clk);
    rd_en = 1'b0;
    seen = rd_valid;
    @(negedge clk);
    seen = seen | rd_valid;
    @(negedge clk);
    seen = seen | rd_valid;
    chk(!seen, req, WW'(seen), '0);
  endtask

  task automatic sweep(int first, string req);
    for (int r = 0; r < ROWS; r++)
      for (int c = 0; c <= 2 * SW; c++)
        read_chk(first, r, c, req);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_run++; n_fail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: quiet after reset
    chk(!win_ready && !rd_valid, "R1", {win_ready, rd_valid}, '0);

    @(negedge clk); row_start = 1'b1;
    @(negedge clk); row_start = 1'b0;
    load_strip(0);
    load_strip(1);
    // R2: two strips are not enough
    chk(!win_ready, "R2", WW'(win_ready), '0);
    // R8: reads ignored while not ready
    read_none(0, 0, "R8");
    load_strip(2);
    chk(win_ready, "R2", WW'(win_ready), 1);
    // R8: column above 32 ignored
    read_none(3, 33, "R8");

    // R3 R5: sweep window 0..2 while strip 3 loads into the spare bank
    fork
      load_strip(3);
      sweep(0, "R3/R5");
    join
    // R7: extra beats with four strips held are ignored
    for (int k = 0; k < 5; k++) begin
      @(negedge clk); ld_valid = 1'b1; ld_data = {16{8'hEE}};
    end
    @(negedge clk); ld_valid = 1'b0;

    pulse_mb();
    // R4: slide keeps ready since strip 3 was preloaded
    chk(win_ready, "R4", WW'(win_ready), 1);
    sweep(1, "R4/R7");

    pulse_mb();
    // R6: no spare strip, ready drops
    chk(!win_ready, "R6", WW'(win_ready), '0);
    pulse_mb();
    chk(!win_ready, "R6", WW'(win_ready), '0);
    load_strip(4);
    chk(win_ready, "R6", WW'(win_ready), 1);
    // R6: extra mb_done ignored, window is strips 2,3,4
    sweep(2, "R6");

    @(negedge clk); row_start = 1'b1;
    @(negedge clk); row_start = 1'b0;
    // R9: row start clears the window
    chk(!win_ready, "R9", WW'(win_ready), '0);
    load_strip(10);
    load_strip(11);
    chk(!win_ready, "R9", WW'(win_ready), '0);
    load_strip(12);
    chk(win_ready, "R9", WW'(win_ready), 1);
    sweep(10, "R9");

    finished = 1;
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule